// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

The block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. Internally it is a grid of `WIDTH` rows of `WIDTH` cells. Each cell forms the AND of one multiplicand bit and one multiplier bit, then adds it with a full adder to a partial sum arriving from the row above and a carry rippling in from its lower neighbour. Row `i` handles multiplier bit `i`. Each row settles one finished product bit, at weight `2^i`, and passes the remaining `WIDTH` upper bits of the running sum down to the next row.

A register bank sits after every row. It holds the partial sum, the operands still needed by later rows, the product bits already settled and a valid flag. A fresh operand pair can therefore enter on every clock, and each result leaves after a fixed number of edges. There is no stall input. A result is presented for exactly one cycle, together with its valid strobe.

Top module: `pipe_array_mult`

## Requirements
- R1: When `out_vld` is high, `product` equals the unsigned product `op_a * op_b` of the pair that produced it, written as `2*WIDTH` bits with bit 0 as the least significant bit.
- R2: A pair sampled with `in_vld` high at rising edge n appears on `product`, with `out_vld` high, right after rising edge n+WIDTH-1. The latency is therefore WIDTH edges, counting the edge that sampled the pair, and it never varies.
- R3: Pairs presented on consecutive cycles come out on consecutive cycles, in the same order, each with its own correct product.
- R4: `out_vld` is high in exactly those cycles that are WIDTH edges after an edge that sampled `in_vld` high. Idle input cycles give idle output cycles in the same places.
- R5: The reset `rst_n` is synchronous and active low. While it is low, `out_vld` is 0. A pair presented with `in_vld` high during reset never produces an `out_vld` pulse after release.
- R6: The extreme operands give exact results: zero times any value gives 0, and all-ones times all-ones gives (2^WIDTH-1)^2, which is 961 for WIDTH=5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the valid pipeline |
| in_vld | input | 1 | Marks `op_a`/`op_b` as a pair to multiply this cycle |
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| out_vld | output | 1 | Marks `product` as holding a result this cycle |
| product | output | 2*WIDTH | Unsigned product |

## Verification
A wrong bit in a row's partial-sum or operand register corrupts only the bits of that pair's product at or above the row's weight. The error shows exactly WIDTH-1-i cycles after the fault in row i, so the bench compares every result against an independent multiplication taken at its issue time. A dropped or duplicated valid bit shows as a missing or extra `out_vld` pulse at a fixed offset. For this reason the bench checks the valid strobe on every cycle, and it drives gapped traffic as well as back-to-back traffic. Exhaustive operand sweeps reach every cell's carry path.

// File: rtl/mult_pkg.sv
// Package: shared helpers for the pipelined array multiplier.
// Assumes: nothing; pure functions only.
package mult_pkg;

    // One-bit full adder; returns {carry, sum}.
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic z);
        return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
    endfunction

endpackage

// File: rtl/mult_pp_cell.sv
// Module: one array cell. ANDs a multiplicand bit with a multiplier bit and
// adds the result to an incoming partial-sum bit and carry.
// Assumes: purely combinational; registering is done by the enclosing row.
module mult_pp_cell
    import mult_pkg::*;
(
    input  logic a_bit,
    input  logic x_bit,
    input  logic s_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);

    // Partial-product bit added through a full adder.
    assign {c_out, s_out} = full_add(a_bit & x_bit, s_in, c_in);

endmodule

// File: rtl/mult_array_row.sv
// Module: one pipelined row of the array, handling multiplier bit ROW.
// Adds (a AND b[ROW]) to the upper running-sum bits, settles product bit ROW,
// and registers everything the later rows need.
// Assumes: acc_i holds the running sum divided by 2^ROW; operand and settled
// bits arrive aligned with acc_i. Only the valid flag is reset.
module mult_array_row #(
    parameter int WIDTH = 5,
    parameter int ROW   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] done_i,
    output logic             vld_o,
    output logic [WIDTH-1:0] a_o,
    output logic [WIDTH-1:0] b_o,
    output logic [WIDTH-1:0] acc_o,
    output logic [WIDTH-1:0] done_o
);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum;

    assign carry[0] = 1'b0;

    // Ripple chain of WIDTH cells across the row.
    for (genvar m = 0; m < WIDTH; m++) begin : g_cell
        mult_pp_cell u_cell (
            .a_bit (a_i[m]),
            .x_bit (b_i[ROW]),
            .s_in  (acc_i[m]),
            .c_in  (carry[m]),
            .s_out (sum[m]),
            .c_out (carry[m+1])
        );
    end

    // Valid flag: cleared by reset, otherwise follows the row input.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Data stage: shift sum down, settle bit ROW, forward operands.
    always_ff @(posedge clk) begin
        a_o         <= a_i;
        b_o         <= b_i;
        acc_o       <= {carry[WIDTH], sum[WIDTH-1:1]};
        done_o      <= done_i;
        done_o[ROW] <= sum[0];
    end

endmodule

// File: rtl/pipe_array_mult.sv
// Module: top of the pipelined unsigned array multiplier.
// Chains WIDTH registered rows; accepts one pair per clock, with a fixed
// latency of WIDTH edges.
// Assumes: no backpressure; the downstream side takes each result when
// out_vld is high.
module pipe_array_mult #(
    parameter int WIDTH = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               out_vld,
    output logic [2*WIDTH-1:0] product
);

    localparam int STAGES = WIDTH;

    logic             vld_p  [0:STAGES];
    logic [WIDTH-1:0] a_p    [0:STAGES];
    logic [WIDTH-1:0] b_p    [0:STAGES];
    logic [WIDTH-1:0] acc_p  [0:STAGES];
    logic [WIDTH-1:0] done_p [0:STAGES];

    // Pipeline entry: operands in, empty running sum.
    assign vld_p[0]  = in_vld;
    assign a_p[0]    = op_a;
    assign b_p[0]    = op_b;
    assign acc_p[0]  = '0;
    assign done_p[0] = '0;

    // One registered row per multiplier bit.
    for (genvar r = 0; r < STAGES; r++) begin : g_row
        mult_array_row #(.WIDTH(WIDTH), .ROW(r)) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (vld_p[r]),
            .a_i    (a_p[r]),
            .b_i    (b_p[r]),
            .acc_i  (acc_p[r]),
            .done_i (done_p[r]),
            .vld_o  (vld_p[r+1]),
            .a_o    (a_p[r+1]),
            .b_o    (b_p[r+1]),
            .acc_o  (acc_p[r+1]),
            .done_o (done_p[r+1])
        );
    end

    // Result: upper bits from the final running sum, lower from settled bits.
    assign out_vld = vld_p[STAGES];
    assign product = {acc_p[STAGES], done_p[STAGES]};

endmodule

// File: rtl/pipe_array_mult_chk.sv
// Module: assertion checker for pipe_array_mult, attached by bind.
// Keeps its own delay line of valid flags and reference products.
// Assumes: the latency is WIDTH edges, counting the edge that samples the inputs.
module pipe_array_mult_chk #(
    parameter int WIDTH = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_vld,
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic               out_vld,
    input logic [2*WIDTH-1:0] product
);

    localparam int LAT = WIDTH;
    localparam logic [2*WIDTH-1:0] MAXP =
        {{WIDTH{1'b0}}, {WIDTH{1'b1}}} * {{WIDTH{1'b0}}, {WIDTH{1'b1}}};

    logic               hv [0:LAT-1];
    logic [2*WIDTH-1:0] hp [0:LAT-1];

    // Reference delay line: valid history is reset, products are not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) hv[i] <= 1'b0;
        end else begin
            hv[0] <= in_vld;
            for (int i = 1; i < LAT; i++) hv[i] <= hv[i-1];
        end
        hp[0] <= {{WIDTH{1'b0}}, op_a} * {{WIDTH{1'b0}}, op_b};
        for (int i = 1; i < LAT; i++) hp[i] <= hp[i-1];
    end

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == hv[LAT-1]);

    p_product_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> product == hp[LAT-1]);

    p_product_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> product <= MAXP);

    p_reset_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_vld);

endmodule

bind pipe_array_mult pipe_array_mult_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_pipe_array_mult.sv
// Bench: scoreboard for pipe_array_mult. The driver queues expected products
// with their issue edge; the monitor pops and compares them on the falling edge.
module sim_pipe_array_mult;

    localparam int W   = 5;
    localparam int LAT = W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_vld;
    logic [W-1:0]     op_a, op_b;
    logic             out_vld;
    logic [2*W-1:0]   product;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;

    logic [2*W-1:0] exp_q [$];
    int             iss_q [$];
    string          tag_q [$];

    pipe_array_mult #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .product(product)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        @(negedge clk);
        in_vld = 1'b1;
        op_a   = a;
        op_b   = b;
        exp_q.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
        iss_q.push_back(cyc + 1);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            op_a   = W'($urandom);
            op_b   = W'($urandom);
        end
    endtask

    // Monitor: valid must match the queue head's due edge; products must match.
    always @(negedge clk) begin
        if (mon_on) begin
            bit due;
            due = (iss_q.size() > 0) && (iss_q[0] + LAT - 1 == cyc);
            check(out_vld === due, "R4 R2", "out_vld alignment", out_vld, due);
            if (due) begin
                if (out_vld === 1'b1)
                    check(product === exp_q[0], tag_q[0], "product (R2 latency)", product, exp_q[0]);
                void'(exp_q.pop_front());
                void'(iss_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=%0d expected=<20000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        in_vld = 1'b1;          // presented during reset; must be dropped (R5)
        op_a   = 5'd7;
        op_b   = 5'd9;
        repeat (3) @(negedge clk);
        check(out_vld === 1'b0, "R5", "out_vld in reset", out_vld, 0);
        @(negedge clk);
        rst_n  = 1'b1;
        in_vld = 1'b0;
        mon_on = 1'b1;
        for (int i = 0; i < LAT + 2; i++) begin
            @(negedge clk);
            check(out_vld === 1'b0, "R5", "out_vld after release", out_vld, 0);
        end

        // Extreme operands, back to back (R6, R3).
        send('0, '0, "R6");
        send('0, '1, "R6");
        send('1, '0, "R6");
        send('1, '1, "R6");
        send('1, 5'd1, "R6");
        idle(LAT + 1);

        // Random back-to-back stream (R3).
        for (int i = 0; i < 40; i++) send(W'($urandom), W'($urandom), "R3");
        idle(2);

        // Gapped traffic: idle gaps must reappear at the output (R4).
        for (int i = 0; i < 20; i++) begin
            send(W'($urandom), W'($urandom), "R4");
            idle(i % 3);
        end
        idle(LAT + 1);

        // Exhaustive sweep, back to back (R1).
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                send(W'(a), W'(b), "R1");
        idle(LAT + 3);

        check(exp_q.size() == 0, "R2", "results outstanding at end", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule